// File: doc/BRIEF.md
# Performance Level Override Controller

This block chooses the performance level that is handed to a downstream clock generator and voltage controller. Software stores a target level through a small register write port. A hardware request can take priority over that setting and force the top level for as long as it is held. The request may arrive at any time relative to the clock, so it passes through a two-stage synchronizer before anything reacts to it. Software can mask it.

The request is the OR of a dedicated active-high line and two active-low interrupt lines, a normal one and a fast one, each inverted. Tying the interrupt outputs of the system here forces full performance while an interrupt is pending. When the request drops, the output returns to whatever software last stored, including values written while the override was active. If an unmasked override begins while the stored level is zero (the off state), the block emits a one-cycle wake pulse together with the jump to the top level. A one-cycle strobe marks every change of the output level, and a status bit shows whether the override is currently in force.

Top module: `perf_override_ctrl`

## Requirements
- R1: After reset, level_out is 7, level_changed, wake and forced are 0, register 0 reads 7, register 1 reads 0 and register 2 reads 0.
- R2: A change of the combined request made between clock edges shows on level_out after the third rising edge, and level_out is still unchanged after the second.
- R3: Register 1 bit 0 is the mask (1 = masked). While it is set, a request leaves level_out at the stored software level and forced at 0. Setting it while a request is held returns level_out to the software level one edge after the write lands.
- R4: While the synchronized request is present and unmasked, level_out is 7 and forced is 1, whatever value register 0 holds.
- R5: With no active override, a write to register 0 shows on level_out one edge after the write edge. When the override ends, level_out returns to the most recent content of register 0, including writes made during the override. A write landing on the same edge as the synchronized release is used directly, with no intermediate level.
- R6: When an unmasked override begins while register 0 holds 0, wake is 1 for exactly one cycle, in the same cycle that level_out becomes 7. Writing 0 to register 0 during an override already in force raises no wake.
- R7: The combined request is hw_req OR (NOT irq_n) OR (NOT fiq_n), and each of the three sources alone causes the override.
- R8: level_changed is 1 for exactly one cycle in each cycle in which level_out differs from its value in the previous cycle, and is 0 otherwise.
- R9: Register map: address 0 holds the 3-bit software level in bits 2:0, address 1 holds the mask in bit 0 with other bits reading 0, address 2 returns forced in bit 0 with other bits reading 0 and ignores writes. rd_data is combinational from rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 3 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 3 | Register read data (combinational) |
| hw_req | input | 1 | Asynchronous active-high override request |
| irq_n | input | 1 | Active-low normal interrupt line, part of the request |
| fiq_n | input | 1 | Active-low fast interrupt line, part of the request |
| level_out | output | 3 | Selected performance level, 0 = off, 7 = maximum |
| level_changed | output | 1 | One-cycle strobe when level_out changes |
| wake | output | 1 | One-cycle pulse when an override leaves the off level |
| forced | output | 1 | Output level is currently forced by the override |

## Verification
Two functions can act on the same edge: the synchronized release of the override and a software write to the level register. The bench schedules the write so that it lands on the same edge on which the second synchronizer stage drops. It then checks that level_out moves directly from 7 to the new value with one strobe and never shows the old stored value. A second collision is the wake pulse and the change strobe: when the level is 0 and an unmasked request rises, the bench checks that both are high in the same cycle as the jump to 7, and that both are low in the next cycle.

// File: rtl/perf_ovr_pkg.sv
package perf_ovr_pkg;

  typedef enum logic [1:0] {
    REG_LEVEL = 2'd0,
    REG_MASK  = 2'd1,
    REG_STAT  = 2'd2,
    REG_RSVD  = 2'd3
  } perf_reg_e;

  localparam int REG_ADDR_W = 2;

endpackage

// File: rtl/perf_ovr_sync.sv
module perf_ovr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

  // R2: first stage follows the raw input one edge later
  p_first_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    din |=> stage_q[0]);
  p_first_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !din |=> !stage_q[0]);

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage_chk
    // R2: each later stage follows its predecessor by one edge
    p_stage_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stage_q[gi-1] |=> stage_q[gi]);
    p_stage_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_q[gi-1] |=> !stage_q[gi]);
  end

endmodule

// File: rtl/perf_ovr_regs.sv
module perf_ovr_regs
  import perf_ovr_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [LVL_W-1:0]      wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  input  logic                  forced,
  output logic [LVL_W-1:0]      rd_data,
  output logic [LVL_W-1:0]      sw_level,
  output logic                  mask
);

  localparam logic [LVL_W-1:0] LVL_RESET = '1;
  localparam logic [LVL_W-1:0] PAD_ZERO  = '0;

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             mask_q, mask_d;
  logic             lvl_en, mask_en;

  always_comb begin
    lvl_en  = wr_en && (wr_addr == REG_LEVEL);
    mask_en = wr_en && (wr_addr == REG_MASK);
    lvl_d   = lvl_en  ? wr_data    : lvl_q;
    mask_d  = mask_en ? wr_data[0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= LVL_RESET;
      mask_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    unique case (rd_addr)
      REG_LEVEL: rd_data = lvl_q;
      REG_MASK:  rd_data = {PAD_ZERO[LVL_W-1:1], mask_q};
      REG_STAT:  rd_data = {PAD_ZERO[LVL_W-1:1], forced};
      default:   rd_data = PAD_ZERO;
    endcase
  end

  assign sw_level = lvl_q;
  assign mask     = mask_q;

  // R9: the status address is read-only
  p_stat_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_STAT) |=> ($stable(lvl_q) && $stable(mask_q)));

  // R9: a level write is stored as written
  p_lvl_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_LEVEL) |=> (lvl_q == $past(wr_data)));

endmodule

// File: rtl/perf_ovr_select.sv
module perf_ovr_select #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_sync,
  input  logic             mask,
  input  logic [LVL_W-1:0] sw_level,
  output logic [LVL_W-1:0] level,
  output logic             level_changed,
  output logic             wake,
  output logic             forced
);

  localparam logic [LVL_W-1:0] LVL_MAX = '1;
  localparam logic [LVL_W-1:0] LVL_OFF = '0;

  logic             ovr_active;
  logic [LVL_W-1:0] level_q, level_d;
  logic             chg_q, chg_d;
  logic             wake_q, wake_d;
  logic             forced_q, forced_d;

  always_comb begin
    ovr_active = req_sync && !mask;
    level_d    = ovr_active ? LVL_MAX : sw_level;
    forced_d   = ovr_active;
    chg_d      = (level_d != level_q);
    wake_d     = ovr_active && !forced_q && (sw_level == LVL_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= LVL_MAX;
      chg_q    <= 1'b0;
      wake_q   <= 1'b0;
      forced_q <= 1'b0;
    end else begin
      level_q  <= level_d;
      chg_q    <= chg_d;
      wake_q   <= wake_d;
      forced_q <= forced_d;
    end
  end

  assign level         = level_q;
  assign level_changed = chg_q;
  assign wake          = wake_q;
  assign forced        = forced_q;

  // R4: forced output always carries the top level
  p_forced_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    forced_q |-> (level_q == LVL_MAX));

  // R5: unforced output tracks the stored level of the previous cycle
  p_sw_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !forced_q |-> (level_q == $past(sw_level)));

  // R3: a mask in force on the previous cycle prevents forcing
  p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask) |-> !forced_q);

  // R6: wake only with the jump out of the off level
  p_wake_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (forced_q && level_q == LVL_MAX && $past(sw_level) == LVL_OFF));
  p_wake_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);

  // R8: strobe exactly when the output moved
  p_chg_on_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> chg_q);
  p_chg_only_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (level_q != $past(level_q)));

endmodule

// File: rtl/perf_override_ctrl.sv
module perf_override_ctrl
  import perf_ovr_pkg::*;
#(
  parameter int LVL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [LVL_W-1:0]      wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [LVL_W-1:0]      rd_data,
  input  logic                  hw_req,
  input  logic                  irq_n,
  input  logic                  fiq_n,
  output logic [LVL_W-1:0]      level_out,
  output logic                  level_changed,
  output logic                  wake,
  output logic                  forced
);

  logic             req_raw;
  logic             req_sync;
  logic [LVL_W-1:0] sw_level;
  logic             mask;
  logic             forced_w;

  // R7: request is the OR of the active-high line and the inverted interrupts
  assign req_raw = hw_req | ~irq_n | ~fiq_n;

  perf_ovr_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (req_raw),
    .dout  (req_sync)
  );

  perf_ovr_regs #(
    .LVL_W (LVL_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .forced   (forced_w),
    .rd_data  (rd_data),
    .sw_level (sw_level),
    .mask     (mask)
  );

  perf_ovr_select #(
    .LVL_W (LVL_W)
  ) u_sel (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_sync      (req_sync),
    .mask          (mask),
    .sw_level      (sw_level),
    .level         (level_out),
    .level_changed (level_changed),
    .wake          (wake),
    .forced        (forced_w)
  );

  assign forced = forced_w;

  // R1: nothing is forced or pulsed while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!forced && !wake && !level_changed));

  // R7: a synchronized request with mask clear forces on the next edge
  p_req_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sync && !mask) |=> forced);

endmodule

// File: tb/perf_override_ctrl_tb.sv
module perf_override_ctrl_tb;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [2:0] wr_data;
  logic [1:0] rd_addr;
  logic [2:0] rd_data;
  logic       hw_req;
  logic       irq_n;
  logic       fiq_n;
  logic [2:0] level_out;
  logic       level_changed;
  logic       wake;
  logic       forced;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  perf_override_ctrl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .hw_req        (hw_req),
    .irq_n         (irq_n),
    .fiq_n         (fiq_n),
    .level_out     (level_out),
    .level_changed (level_changed),
    .wake          (wake),
    .forced        (forced)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [2:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic set_req(input int src, input bit val);
    case (src)
      0:       hw_req = val;
      1:       irq_n  = !val;
      default: fiq_n  = !val;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    int exp_hi;
    int new_lvl;
    int exp_after;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
    hw_req  = 1'b0;
    irq_n   = 1'b1;
    fiq_n   = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_eq("R1 level_out", int'(level_out), 7);
    check_eq("R1 level_changed", int'(level_changed), 0);
    check_eq("R1 wake", int'(wake), 0);
    check_eq("R1 forced", int'(forced), 0);
    reg_read(2'd0, v); check_eq("R1 reg0", v, 7);
    reg_read(2'd1, v); check_eq("R1 reg1", v, 0);
    reg_read(2'd2, v); check_eq("R1 reg2", v, 0);

    // Sweep: every source, mask setting and stored level
    for (int src = 0; src < 3; src++) begin
      for (int msk = 0; msk < 2; msk++) begin
        for (int lvl = 0; lvl < 8; lvl++) begin
          reg_write(2'd0, 3'(lvl));
          reg_write(2'd1, 3'(msk));
          @(negedge clk);
          check_eq("R5 idle level", int'(level_out), lvl);
          reg_read(2'd0, v); check_eq("R9 reg0 readback", v, lvl);
          reg_read(2'd1, v); check_eq("R9 reg1 readback", v, msk);

          set_req(src, 1'b1);
          repeat (2) @(negedge clk);
          check_eq("R2 not yet after two edges", int'(level_out), lvl);
          check_eq("R2 no strobe yet", int'(level_changed), 0);
          @(negedge clk);
          exp_hi = (msk != 0) ? lvl : 7;
          check_eq($sformatf("R4 R7 R3 level src%0d mask%0d", src, msk),
                   int'(level_out), exp_hi);
          check_eq("R4 R3 forced", int'(forced), (msk == 0) ? 1 : 0);
          check_eq("R8 strobe on rise", int'(level_changed), (exp_hi != lvl) ? 1 : 0);
          check_eq("R6 wake on rise", int'(wake), (msk == 0 && lvl == 0) ? 1 : 0);
          reg_read(2'd2, v); check_eq("R9 reg2 status", v, (msk == 0) ? 1 : 0);
          @(negedge clk);
          check_eq("R6 wake single", int'(wake), 0);
          check_eq("R8 strobe single", int'(level_changed), 0);

          new_lvl = lvl;
          if (msk == 0) begin
            new_lvl = (lvl + 3) % 8;
            reg_write(2'd0, 3'(new_lvl));
            @(negedge clk);
            check_eq("R4 write during override", int'(level_out), 7);
            check_eq("R6 no wake on write", int'(wake), 0);
          end

          set_req(src, 1'b0);
          repeat (2) @(negedge clk);
          check_eq("R2 release not yet", int'(level_out), exp_hi);
          @(negedge clk);
          exp_after = new_lvl;
          check_eq("R5 restore level", int'(level_out), exp_after);
          check_eq("R5 forced clear", int'(forced), 0);
          check_eq("R8 strobe on release", int'(level_changed),
                   (exp_after != exp_hi) ? 1 : 0);
          @(negedge clk);
        end
      end
    end

    // Collision: write lands on the same edge as the synchronized release
    reg_write(2'd1, 3'd0);
    reg_write(2'd0, 3'd2);
    hw_req = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R4 held", int'(level_out), 7);
    hw_req = 1'b0;
    @(negedge clk);
    reg_write(2'd0, 3'd5);
    check_eq("R5 collision still max", int'(level_out), 7);
    @(negedge clk);
    check_eq("R5 collision new level", int'(level_out), 5);
    check_eq("R8 collision strobe", int'(level_changed), 1);
    @(negedge clk);
    check_eq("R5 collision no old level", int'(level_out), 5);
    check_eq("R8 collision strobe clear", int'(level_changed), 0);

    // Mask set and cleared while the request is held
    reg_write(2'd0, 3'd3);
    fiq_n = 1'b0;
    repeat (4) @(negedge clk);
    check_eq("R7 fast line forces", int'(level_out), 7);
    reg_write(2'd1, 3'd1);
    @(negedge clk);
    check_eq("R3 mask drops force", int'(level_out), 3);
    check_eq("R3 mask forced clear", int'(forced), 0);
    reg_write(2'd1, 3'd0);
    @(negedge clk);
    check_eq("R3 unmask forces again", int'(level_out), 7);
    check_eq("R6 no wake at nonzero level", int'(wake), 0);

    // Override in force, then stored level written to zero: no wake
    reg_write(2'd0, 3'd0);
    repeat (2) @(negedge clk);
    check_eq("R6 zero write no wake", int'(wake), 0);
    check_eq("R4 zero write stays max", int'(level_out), 7);

    // Status register ignores writes
    reg_write(2'd2, 3'd0);
    @(negedge clk);
    reg_read(2'd0, v); check_eq("R9 stat write keeps reg0", v, 0);
    reg_read(2'd1, v); check_eq("R9 stat write keeps reg1", v, 0);
    reg_read(2'd2, v); check_eq("R9 stat still forced", v, 1);
    reg_read(2'd3, v); check_eq("R9 unused address reads zero", v, 0);
    fiq_n = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R5 release to zero", int'(level_out), 0);
    reg_read(2'd2, v); check_eq("R9 stat cleared", v, 0);

    // Two sources at once, then one released: override persists
    irq_n  = 1'b0;
    hw_req = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R6 wake from off", int'(wake), 1);
    check_eq("R8 strobe with wake", int'(level_changed), 1);
    irq_n = 1'b0;
    hw_req = 1'b0;
    repeat (4) @(negedge clk);
    check_eq("R7 remaining source holds", int'(level_out), 7);
    irq_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R7 all released", int'(level_out), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule